// File: doc/BRIEF.md
# NAND Page ECC Parity Accumulator

This block builds a running single-error-correct, double-error-detect parity word over the data beats that pass between a controller and one NAND flash bank. Three command pulses control it. Start arms accumulation, stop freezes it, and clear zeroes the parity register and the internal beat counter. While it is armed, every valid beat aimed at the bank named by the bank-select input is folded into the parity. Reads and writes count alike, and the address of the beat inside that bank makes no difference. An active output shows whether accumulation is armed.

In a typical page sequence, software issues clear and start together and moves the 512 main-area bytes. It then issues stop before the spare bytes move, so the parity stays stable for software to read and compare against the stored code. The block produces parity only. It does no comparison, error location or correction.

For each set data bit the code forms a 12-bit address from the beat counter and the bit position. It then toggles one bit of a pair, even or odd, for every address bit. This gives 24 parity bits in a 32-bit register.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset `parity` is 0 and `active` is 0.
- R2: `cmdStart` sets `active` at the next clock edge and `cmdStop` clears it. When both are pulsed in the same cycle, stop wins.
- R3: `cmdClear` zeroes `parity` and the beat counter at the next edge. When it is pulsed together with `cmdStart`, accumulation begins from zero.
- R4: In byte mode (`beatWide`=0), a counted beat at counter value n (beats counted since the last clear, modulo 512) handles each set bit j of `beatData[7:0]` as follows. It forms address a = n*8+j and, for k = 0..11, toggles `parity[2k+a[k]]`. Bits 15:8 of the data are ignored.
- R5: In halfword mode (`beatWide`=1), each set bit j of `beatData[15:0]` uses a = (n mod 256)*16+j, with the same toggling rule as R4.
- R6: A beat whose `beatBank` differs from `bankSel` leaves `parity` and the beat counter unchanged.
- R7: While `active` is 0, beats leave `parity` unchanged. A stop therefore freezes the result.
- R8: `parity[31:24]` is always 0.
- R9: `cmdStart` while already active does not reset `parity` or the beat counter.
- R10: A beat is counted only if `active` was already 1 at that clock edge. A beat in the same cycle as `cmdClear` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | Pulse: arm accumulation |
| cmdStop | input | 1 | Pulse: disarm accumulation |
| cmdClear | input | 1 | Pulse: zero the parity and the beat counter |
| bankSel | input | 2 | Bank whose beats are covered |
| beatValid | input | 1 | A data beat is on the bus this cycle |
| beatWide | input | 1 | 1 = 16-bit beat, 0 = 8-bit beat |
| beatBank | input | 2 | Bank the beat is aimed at |
| beatData | input | 16 | Beat data |
| parity | output | 32 | Accumulated parity word |
| active | output | 1 | Accumulation is armed |

## Verification
One-hot sweeps place a single set bit at every position, in both byte and halfword modes, and at chosen beat indices. Each sweep shows that the bit index and the beat index land in the right even/odd field pairs, and that the two modes read the address differently. A full 512-byte page and a 256-halfword page with varied data check the counter's full range and its wrap. Beats to other banks, beats after stop, a start issued while already active, and beats issued in the same cycle as clear or start tell the filters and command ordering apart from the datapath.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef struct packed {
    logic clearNow;
    logic takeBeat;
  } eccStrobe_t;
endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdStop,
  input  logic              cmdClear,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              beatValid,
  input  logic [BANK_W-1:0] beatBank,
  output eccStrobe_t        strobe,
  output logic              active
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         armed <= 1'b0;
    else if (cmdStop)  armed <= 1'b0;
    else if (cmdStart) armed <= 1'b1;
  end

  always_comb begin
    strobe.clearNow = cmdClear;
    strobe.takeBeat = armed && beatValid && (beatBank == bankSel) && !cmdClear;
  end

  assign active = armed;
endmodule

// File: rtl/nand_ecc_datapath.sv
module nand_ecc_datapath
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BEAT_W = 9,
  parameter int PAR_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  eccStrobe_t        strobe,
  input  logic              beatWide,
  input  logic [DATA_W-1:0] beatData,
  output logic [PAR_W-1:0]  parity
);
  localparam int WIDE_IDX_W   = $clog2(DATA_W);
  localparam int NARROW_IDX_W = WIDE_IDX_W - 1;
  localparam int NARROW_BITS  = DATA_W / 2;
  localparam int ADDR_W       = BEAT_W + NARROW_IDX_W;
  localparam int FIELD_W      = 2 * ADDR_W;

  logic [BEAT_W-1:0]  beatCnt;
  logic [FIELD_W-1:0] fieldReg;
  logic [FIELD_W-1:0] beatFlip;

  always_comb begin
    logic [ADDR_W-1:0] bitAddr;
    logic              bitOn;
    beatFlip = '0;
    for (int j = 0; j < DATA_W; j++) begin
      if (beatWide) begin
        bitAddr = {beatCnt[BEAT_W-2:0], WIDE_IDX_W'(j)};
        bitOn   = beatData[j];
      end else begin
        bitAddr = {beatCnt, NARROW_IDX_W'(j % NARROW_BITS)};
        bitOn   = (j < NARROW_BITS) && beatData[j];
      end
      for (int k = 0; k < ADDR_W; k++) begin
        beatFlip[2*k+1] = beatFlip[2*k+1] ^ (bitOn & bitAddr[k]);
        beatFlip[2*k]   = beatFlip[2*k]   ^ (bitOn & ~bitAddr[k]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatCnt  <= '0;
      fieldReg <= '0;
    end else if (strobe.clearNow) begin
      beatCnt  <= '0;
      fieldReg <= '0;
    end else if (strobe.takeBeat) begin
      beatCnt  <= beatCnt + 1'b1;
      fieldReg <= fieldReg ^ beatFlip;
    end
  end

  generate
    if (PAR_W > FIELD_W) begin : g_pad
      assign parity = {{(PAR_W-FIELD_W){1'b0}}, fieldReg};
    end else begin : g_trim
      assign parity = fieldReg[PAR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BANK_W = 2,
  parameter int BEAT_W = 9,
  parameter int PAR_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdStop,
  input  logic              cmdClear,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              beatValid,
  input  logic              beatWide,
  input  logic [BANK_W-1:0] beatBank,
  input  logic [DATA_W-1:0] beatData,
  output logic [PAR_W-1:0]  parity,
  output logic              active
);
  eccStrobe_t strobe;

  nand_ecc_ctrl #(.BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdStop(cmdStop),
    .cmdClear(cmdClear), .bankSel(bankSel), .beatValid(beatValid),
    .beatBank(beatBank), .strobe(strobe), .active(active)
  );

  nand_ecc_datapath #(.DATA_W(DATA_W), .BEAT_W(BEAT_W), .PAR_W(PAR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .beatWide(beatWide),
    .beatData(beatData), .parity(parity)
  );
endmodule

// File: rtl/nand_ecc_acc_chk.sv
module nand_ecc_acc_chk #(
  parameter int DATA_W = 16,
  parameter int BANK_W = 2,
  parameter int PAR_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdStart,
  input logic              cmdStop,
  input logic              cmdClear,
  input logic [BANK_W-1:0] bankSel,
  input logic              beatValid,
  input logic [BANK_W-1:0] beatBank,
  input logic [PAR_W-1:0]  parity,
  input logic              active
);
  // R2
  start_sets_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart && !cmdStop |=> active);
  // R2
  stop_clears_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStop |=> !active);
  // R3
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdClear |=> parity == '0);
  // R6
  other_bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && beatBank != bankSel && !cmdClear |=> $stable(parity));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active && !cmdClear |=> $stable(parity));
  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    parity[PAR_W-1:24] == '0);
  // R10
  no_beat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !beatValid && !cmdClear |=> $stable(parity));
endmodule

bind nand_ecc_acc nand_ecc_acc_chk #(.DATA_W(DATA_W), .BANK_W(BANK_W), .PAR_W(PAR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdStop(cmdStop),
  .cmdClear(cmdClear), .bankSel(bankSel), .beatValid(beatValid),
  .beatBank(beatBank), .parity(parity), .active(active)
);

// File: tb/sim_nand_ecc_acc.sv
module sim_nand_ecc_acc;
  logic clk = 0, rstN = 0;
  logic cmdStart = 0, cmdStop = 0, cmdClear = 0, beatValid = 0, beatWide = 0;
  logic [1:0] bankSel = 2'd1, beatBank = 0;
  logic [15:0] beatData = 0;
  logic [31:0] parity;
  logic active;
  int nChk = 0, nBad = 0;
  bit done = 0;
  int mPar = 0, mCnt = 0;
  bit mAct = 0;

  always #5 clk = ~clk;

  nand_ecc_acc u0 (.clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdStop(cmdStop),
    .cmdClear(cmdClear), .bankSel(bankSel), .beatValid(beatValid), .beatWide(beatWide),
    .beatBank(beatBank), .beatData(beatData), .parity(parity), .active(active));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    cmdStart = 0; cmdStop = 0; cmdClear = 0; beatValid = 0;
  endtask

  // arithmetic reference: each set bit toggles one bit of each field pair
  task automatic modelBeat(logic [15:0] d, bit wide);
    for (int j = 0; j < (wide ? 16 : 8); j++) begin
      if (d[j]) begin
        int a;
        a = wide ? ((mCnt % 256) * 16 + j) : (mCnt * 8 + j);
        for (int k = 0; k < 12; k++) mPar = mPar ^ (1 << (2 * k + ((a >> k) & 1)));
      end
    end
    mCnt = (mCnt + 1) % 512;
  endtask

  // command and beat in one cycle; the model follows R2, R3, R6, R7, R10
  task automatic cyc(bit s, bit p, bit c, bit v, logic [15:0] d, bit wide, logic [1:0] bk);
    cmdStart = s; cmdStop = p; cmdClear = c;
    beatValid = v; beatData = d; beatWide = wide; beatBank = bk;
    if (c) begin mPar = 0; mCnt = 0; end
    else if (v && mAct && bk == bankSel) modelBeat(d, wide);
    if (p) mAct = 0; else if (s) mAct = 1;
    step();
  endtask

  task automatic beat(logic [15:0] d, bit wide);
    cyc(0, 0, 0, 1, d, wide, bankSel);
  endtask

  task automatic restart();
    cyc(1, 0, 1, 0, 0, 0, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 parity", parity, 0);
    chk("R1 active", {31'd0, active}, 0);
    rstN = 1; @(negedge clk);

    // R4 one-hot sweep, byte mode, beat 0 and beat 5
    for (int j = 0; j < 8; j++) begin
      restart();
      beat(16'(1 << j), 0);
      chk("R4 onehot beat0", parity, mPar);
      restart();
      for (int b = 0; b < 5; b++) beat(0, 0);
      beat(16'(1 << j) | 16'hff00, 0);
      chk("R4 onehot beat5 upper ignored", parity, mPar);
    end
    // R5 one-hot sweep, halfword mode, beat 0 and beat 3
    for (int j = 0; j < 16; j++) begin
      restart();
      beat(16'(1 << j), 1);
      chk("R5 onehot beat0", parity, mPar);
      restart();
      for (int b = 0; b < 3; b++) beat(0, 1);
      beat(16'(1 << j), 1);
      chk("R5 onehot beat3", parity, mPar);
    end
    // R4 full 512-byte page, then wrap of the counter
    restart();
    chk("R2 active after start", {31'd0, active}, 1);
    for (int i = 0; i < 512; i++) beat(16'((i * 37 + 11) & 8'hff), 0);
    chk("R4 full page", parity, mPar);
    beat(16'h00a5, 0);
    chk("R4 counter wrap", parity, mPar);
    chk("R8 upper zero", {24'd0, parity[31:24]}, 0);
    // R5 full halfword page with counter past 256
    restart();
    for (int i = 0; i < 300; i++) beat(16'((i * 4099 + 7) & 16'hffff), 1);
    chk("R5 halfword page", parity, mPar);
    // R6 other bank ignored
    for (int b = 0; b < 4; b++) if (b != 1) cyc(0, 0, 0, 1, 16'h5a3c, 0, 2'(b));
    beat(16'h0001, 1);
    chk("R6 other bank", parity, mPar);
    // R9 start while active keeps state
    cyc(1, 0, 0, 0, 0, 0, 0);
    beat(16'h0081, 0);
    chk("R9 start while active", parity, mPar);
    // R7 stop freezes; beat in stop cycle still counted
    cyc(0, 1, 0, 1, 16'h0033, 0, 2'd1);
    chk("R2 stop clears active", {31'd0, active}, 0);
    chk("R7 stop cycle beat", parity, mPar);
    for (int i = 0; i < 10; i++) beat(16'(i * 13 + 1), 0);
    chk("R7 frozen after stop", parity, mPar);
    // R2 start and stop together: stop wins
    cyc(1, 1, 0, 0, 0, 0, 0);
    chk("R2 stop wins", {31'd0, active}, 0);
    // R10 beat in start cycle ignored; beat in clear cycle dropped
    cyc(1, 0, 1, 1, 16'h00ff, 0, 2'd1);
    chk("R3 clear with start", parity, 0);
    chk("R10 start-cycle beat ignored", parity, mPar);
    beat(16'h0004, 0);
    cyc(0, 0, 1, 1, 16'h0010, 0, 2'd1);
    chk("R10 clear-cycle beat dropped", parity, 0);
    beat(16'h0002, 0);
    chk("R3 counter reset by clear", parity, mPar);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule